// File: doc/BRIEF.md
# Pin interrupt channel controller

The controller gathers interrupt requests from general-purpose port pins into a small number of interrupt channels. Pins come in half-ports of eight. A channel has four slots, and each slot can be given any one half-port, so one channel watches up to 32 pins. The same half-port may be given to more than one channel, and each of those channels then holds its own view of those pins. Interrupt detection reads only the pin levels. It does not depend on how the pins are driven or used elsewhere.

Each slot bit of a channel has three settings: detection by edge or by level, inversion of its active sense, and a mask bit. An edge event is held in a per-bit latch until software clears it. A level request follows the pin. The latches keep working while a bit is masked. Software can always read the latch contents and the synchronized pin levels. The mask, sense and inversion registers each have a plain address, a set address and a clear address. A write of 1 to a bit at the set address sets that bit, and a write of 1 at the clear address clears it. Each channel drives one request line, which is the OR over its slots of latch AND mask.

Top module: `pint_ctrl`

## Requirements
- R1: While rst is high and in the first cycle after it falls, every channel register reads 0 and irq is 0.
- R2: A register address is {channel, offset}. Mask, sense and inversion are at offsets 1, 4 and 7. A write at the base offset stores wdata. A write at base+1 ORs wdata into the register. A write at base+2 clears every bit that is 1 in wdata. Reads at all three offsets return the register.
- R3: Offset 0 is the route register. Byte k configures slot k: bit 7 enables the slot and bits [2:0] hold the half-port index. Only those bits are stored. Offset 12 reads the synchronized pins. Bit 8k+j shows pin 8h+j when slot k is enabled with index h, and reads 0 when the slot is disabled.
- R4: A sense bit of 1 selects edge detection. With inversion 0, a rising edge sets the latch. With inversion 1, a falling edge sets it, and the opposite edge does nothing. The latch bit stays set until a 1 is written to that bit at offset 11. The latch reads at offset 10.
- R5: A sense bit of 0 selects level detection. The latch bit then follows the pin XOR its inversion bit, and a write at offset 11 does not change it.
- R6: The latch records events whether or not the bit is masked. Only the mask decides whether the bit reaches irq.
- R7: irq[c] is 1 exactly when some bit of channel c has both its latch and its mask set. Other channels do not affect it.
- R8: When a clear write to a bit happens in the same cycle as a new edge on that bit, the clear wins and the latch reads 0.
- R9: Two channels routed to the same half-port latch independently. Clearing one channel leaves the other's latch unchanged.
- R10: A pin change reaches the latch at the third rising clock edge after the change. The latch bit still reads its old value after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | NUM_HP*8 | Asynchronous pin levels, half-port h on bits 8h+7..8h |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CH_W+4 | Channel index in upper bits, register offset in low four bits |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | NUM_CH | One request line per channel |

## Verification
The assertions assume that the clear alias is the only write that ever drops a held edge latch. They also assume that each register write lasts one cycle, so one strobe never counts as a clear and a set at once. The stimulus changes pins only on falling clock edges and writes one register per strobe. After each change of routing, sense or inversion it waits for the synchronizer to settle and then clears the latches, so no spurious edge left over from reconfiguration is checked as if it were a real event. The clear-priority case is timed so that the clear write lands exactly on the edge that would otherwise latch the event.

// File: rtl/pint_pkg.sv
package pint_pkg;

    localparam int HP_PINS = 8;
    localparam int SLOTS   = 4;
    localparam int SLOT_W  = HP_PINS * SLOTS;
    localparam int OFF_W   = 4;

    typedef enum logic [OFF_W-1:0] {
        OFF_ROUTE     = 4'd0,
        OFF_MASK      = 4'd1,
        OFF_MASK_SET  = 4'd2,
        OFF_MASK_CLR  = 4'd3,
        OFF_SENSE     = 4'd4,
        OFF_SENSE_SET = 4'd5,
        OFF_SENSE_CLR = 4'd6,
        OFF_INV       = 4'd7,
        OFF_INV_SET   = 4'd8,
        OFF_INV_CLR   = 4'd9,
        OFF_REQ       = 4'd10,
        OFF_REQ_CLR   = 4'd11,
        OFF_PINS      = 4'd12
    } reg_off_e;

    typedef enum logic [1:0] {WK_NONE, WK_PLAIN, WK_SET, WK_CLR} wr_kind_e;

    typedef struct packed {
        logic [SLOT_W-1:0] route;
        logic [SLOT_W-1:0] mask;
        logic [SLOT_W-1:0] sense;
        logic [SLOT_W-1:0] inv;
    } ch_cfg_t;

    // Which of the three aliases of a register an offset hits.
    function automatic wr_kind_e kind_for(logic [OFF_W-1:0] off, reg_off_e base);
        logic [OFF_W-1:0] b;
        b = base;
        if (off == b)         return WK_PLAIN;
        if (off == b + 4'd1)  return WK_SET;
        if (off == b + 4'd2)  return WK_CLR;
        return WK_NONE;
    endfunction

    function automatic logic [SLOT_W-1:0] apply_kind(logic [SLOT_W-1:0] cur,
                                                     logic [SLOT_W-1:0] wd,
                                                     wr_kind_e          k);
        case (k)
            WK_PLAIN: return wd;
            WK_SET:   return cur | wd;
            WK_CLR:   return cur & ~wd;
            default:  return cur;
        endcase
    endfunction

    // Bits of the route register that are stored: enable plus index per byte.
    function automatic logic [SLOT_W-1:0] route_keep(int hp_w);
        logic [SLOT_W-1:0] m;
        m = '0;
        for (int k = 0; k < SLOTS; k++) begin
            m[k*HP_PINS + HP_PINS - 1] = 1'b1;
            for (int b = 0; b < hp_w; b++) m[k*HP_PINS + b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] now_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end
endmodule

// File: rtl/pint_slot_mux.sv
module pint_slot_mux
    import pint_pkg::*;
#(
    parameter int NUM_HP = 8,
    parameter int HP_W   = 3
) (
    input  logic [SLOT_W-1:0]         route,
    input  logic [NUM_HP*HP_PINS-1:0] pin_now,
    input  logic [NUM_HP*HP_PINS-1:0] pin_prev,
    output logic [SLOT_W-1:0]         slot_now,
    output logic [SLOT_W-1:0]         slot_prev
);
    logic unused_route;
    assign unused_route = ^route;

    always_comb begin
        slot_now  = '0;
        slot_prev = '0;
        for (int k = 0; k < SLOTS; k++) begin
            for (int h = 0; h < NUM_HP; h++) begin
                if (route[k*HP_PINS + HP_PINS - 1] &&
                    route[k*HP_PINS +: HP_W] == HP_W'(h)) begin
                    slot_now[k*HP_PINS +: HP_PINS]  = pin_now[h*HP_PINS +: HP_PINS];
                    slot_prev[k*HP_PINS +: HP_PINS] = pin_prev[h*HP_PINS +: HP_PINS];
                end
            end
        end
    end
endmodule

// File: rtl/pint_channel.sv
module pint_channel
    import pint_pkg::*;
#(
    parameter int NUM_HP = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [OFF_W-1:0]          off,
    input  logic [SLOT_W-1:0]         wdata,
    input  logic [NUM_HP*HP_PINS-1:0] pin_now,
    input  logic [NUM_HP*HP_PINS-1:0] pin_prev,
    output ch_cfg_t                   cfg,
    output logic [SLOT_W-1:0]         req,
    output logic [SLOT_W-1:0]         slot_now,
    output logic                      irq
);
    localparam int HP_W = (NUM_HP > 1) ? $clog2(NUM_HP) : 1;
    localparam logic [SLOT_W-1:0] ROUTE_KEEP = route_keep(HP_W);

    ch_cfg_t           cfg_q, cfg_d;
    logic [SLOT_W-1:0] req_q, req_d;
    logic [SLOT_W-1:0] slot_prev, act_now, act_prev, clr_bits, edge_hit;

    pint_slot_mux #(.NUM_HP(NUM_HP), .HP_W(HP_W)) u_mux (
        .route     (cfg_q.route),
        .pin_now   (pin_now),
        .pin_prev  (pin_prev),
        .slot_now  (slot_now),
        .slot_prev (slot_prev)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (off == OFF_ROUTE) cfg_d.route = wdata & ROUTE_KEEP;
            cfg_d.mask  = apply_kind(cfg_q.mask,  wdata, kind_for(off, OFF_MASK));
            cfg_d.sense = apply_kind(cfg_q.sense, wdata, kind_for(off, OFF_SENSE));
            cfg_d.inv   = apply_kind(cfg_q.inv,   wdata, kind_for(off, OFF_INV));
        end
    end

    always_comb begin
        clr_bits = (we && off == OFF_REQ_CLR) ? wdata : '0;
        act_now  = slot_now  ^ cfg_q.inv;
        act_prev = slot_prev ^ cfg_q.inv;
        edge_hit = act_now & ~act_prev;
        // Edge bits: sticky, clear beats a same-cycle event. Level bits: follow pin.
        req_d    = (cfg_q.sense & (req_q | edge_hit) & ~clr_bits)
                 | (~cfg_q.sense & act_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            req_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            req_q <= req_d;
        end
    end

    assign cfg = cfg_q;
    assign req = req_q;
    assign irq = |(req_q & cfg_q.mask);
endmodule

// File: rtl/pint_ctrl.sv
module pint_ctrl
    import pint_pkg::*;
#(
    parameter int NUM_HP = 8,
    parameter int NUM_CH = 6,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W   = CH_W + OFF_W,
    localparam int NUM_PINS = NUM_HP * HP_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [SLOT_W-1:0]   reg_wdata,
    output logic [SLOT_W-1:0]   reg_rdata,
    output logic [NUM_CH-1:0]   irq
);
    logic [NUM_PINS-1:0] pin_now, pin_prev;
    logic [CH_W-1:0]     sel_ch;
    logic [OFF_W-1:0]    sel_off;

    logic [NUM_CH-1:0][SLOT_W-1:0] ch_req, ch_mask, ch_sense, ch_inv, ch_route, ch_pins;
    ch_cfg_t ch_cfg [NUM_CH];

    assign sel_ch  = reg_addr[ADDR_W-1:OFF_W];
    assign sel_off = reg_addr[OFF_W-1:0];

    pint_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (pins),
        .now_q  (pin_now),
        .prev_q (pin_prev)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pint_channel #(.NUM_HP(NUM_HP)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .we       (reg_we && sel_ch == CH_W'(c)),
            .off      (sel_off),
            .wdata    (reg_wdata),
            .pin_now  (pin_now),
            .pin_prev (pin_prev),
            .cfg      (ch_cfg[c]),
            .req      (ch_req[c]),
            .slot_now (ch_pins[c]),
            .irq      (irq[c])
        );
        assign ch_route[c] = ch_cfg[c].route;
        assign ch_mask[c]  = ch_cfg[c].mask;
        assign ch_sense[c] = ch_cfg[c].sense;
        assign ch_inv[c]   = ch_cfg[c].inv;
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel_ch == CH_W'(c)) begin
                case (reg_off_e'(sel_off))
                    OFF_ROUTE:                              reg_rdata = ch_route[c];
                    OFF_MASK, OFF_MASK_SET, OFF_MASK_CLR:   reg_rdata = ch_mask[c];
                    OFF_SENSE, OFF_SENSE_SET, OFF_SENSE_CLR: reg_rdata = ch_sense[c];
                    OFF_INV, OFF_INV_SET, OFF_INV_CLR:      reg_rdata = ch_inv[c];
                    OFF_REQ, OFF_REQ_CLR:                   reg_rdata = ch_req[c];
                    OFF_PINS:                               reg_rdata = ch_pins[c];
                    default:                                reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pint_ctrl_chk.sv
module pint_ctrl_chk #(
    parameter int NUM_CH = 6,
    parameter int CH_W   = 3,
    localparam int ADDR_W = CH_W + 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   reg_we,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [31:0]            reg_wdata,
    input logic [NUM_CH-1:0]      irq,
    input logic [NUM_CH-1:0][31:0] ch_req,
    input logic [NUM_CH-1:0][31:0] ch_mask,
    input logic [NUM_CH-1:0][31:0] ch_sense
);
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (irq == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        localparam logic [ADDR_W-1:0] A_CLR  = {CH_W'(c), 4'd11};
        localparam logic [ADDR_W-1:0] A_MSET = {CH_W'(c), 4'd2};

        p_set_keeps_r2: assert property (@(posedge clk) disable iff (rst)
            (reg_we && reg_addr == A_MSET) |=> (($past(ch_mask[c]) & ~ch_mask[c]) == '0));

        p_latch_holds_r4: assert property (@(posedge clk) disable iff (rst)
            (|($past(ch_req[c] & ch_sense[c]) & ~ch_req[c]))
            |-> $past(reg_we && reg_addr == A_CLR));

        p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
            irq[c] |-> (ch_mask[c] != '0));

        p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
            (reg_we && reg_addr == A_CLR)
            |=> ((ch_req[c] & $past(reg_wdata) & $past(ch_sense[c]) & ch_sense[c]) == '0));
    end
endmodule

bind pint_ctrl pint_ctrl_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .ch_req(ch_req),
    .ch_mask(ch_mask), .ch_sense(ch_sense)
);

// File: tb/pint_ctrl_tb.sv
module pint_ctrl_tb;
    localparam int NUM_HP = 8;
    localparam int NUM_CH = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] pins = '0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] v;

    always #4 clk = ~clk;

    pint_ctrl #(.NUM_HP(NUM_HP), .NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst(rst), .pins(pins), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int c, int o, logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = {3'(c), 4'(o)};
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(int c, int o, output logic [31:0] r);
        @(negedge clk);
        reg_addr = {3'(c), 4'(o)};
        #1 r = reg_rdata;
    endtask

    function automatic logic [7:0] pat(int h);
        return 8'h3C ^ (8'(h) * 8'h25);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        // R1: reset values
        #1 chk("R1 irq", 32'(irq), 0);
        for (int c = 0; c < NUM_CH; c++) begin
            rd(c, 0, v);  chk("R1 route", v, 0);
            rd(c, 1, v);  chk("R1 mask", v, 0);
            rd(c, 4, v);  chk("R1 sense", v, 0);
            rd(c, 7, v);  chk("R1 inv", v, 0);
            rd(c, 10, v); chk("R1 req", v, 0);
            rd(c, 12, v); chk("R1 pins", v, 0);
        end

        // R2: plain / set / clear aliases on every channel and register
        for (int c = 0; c < NUM_CH; c++) begin
            for (int r = 0; r < 3; r++) begin
                logic [31:0] a, b, cl;
                int base;
                base = 1 + 3 * r;
                a  = 32'hA5C3_0F01 ^ (32'(c) << (4 * r));
                b  = 32'h0F0F_1234 << c;
                cl = 32'h8181_FF00 >> r;
                wr(c, base, a);       rd(c, base, v);     chk("R2 plain", v, a);
                wr(c, base + 1, b);   rd(c, base + 1, v); chk("R2 set", v, a | b);
                wr(c, base + 2, cl);  rd(c, base + 2, v); chk("R2 clear", v, (a | b) & ~cl);
                wr(c, base, 0);
            end
        end

        // R3: routing of every half-port into every slot
        wr(0, 0, 32'hFFFF_FFFF);
        rd(0, 0, v); chk("R3 route keep", v, 32'h8787_8787);
        wr(0, 0, 0);
        for (int h = 0; h < NUM_HP; h++) pins[h*8 +: 8] = pat(h);
        tick(4);
        for (int k = 0; k < 4; k++) begin
            for (int h = 0; h < NUM_HP; h++) begin
                wr(0, 0, (32'h80 | 32'(h)) << (8 * k));
                rd(0, 12, v); chk("R3 routed pins", v, 32'(pat(h)) << (8 * k));
            end
            wr(0, 0, 32'h05 << (8 * k));
            rd(0, 12, v); chk("R3 disabled slot", v, 0);
        end
        rd(1, 12, v); chk("R3 unrouted channel", v, 0);
        pins = '0;
        wr(0, 0, 32'h81);
        wr(0, 4, 32'hFFFF_FFFF);
        wr(0, 7, 0);
        wr(0, 1, 32'hFFFF_FFFF);
        tick(4);
        wr(0, 11, 32'hFFFF_FFFF);

        // R4: rising edges latch and hold until cleared
        for (int j = 0; j < 8; j++) begin
            pins[8 + j] = 1'b1; tick(4);
            rd(0, 10, v); chk("R4 rise latched", v, 32'(1) << j);
            chk("R4 irq up", 32'(irq), 1);
            pins[8 + j] = 1'b0; tick(4);
            rd(0, 10, v); chk("R4 held after fall", v, 32'(1) << j);
            wr(0, 11, 32'(1) << j);
            rd(0, 10, v); chk("R4 cleared", v, 0);
            chk("R4 irq down", 32'(irq), 0);
        end
        // R4: inverted bits latch falling edges only
        wr(0, 7, 32'hFF);
        tick(4);
        for (int j = 0; j < 8; j++) begin
            pins[8 + j] = 1'b1; tick(4);
            rd(0, 10, v); chk("R4 inverted rise ignored", v, 0);
            pins[8 + j] = 1'b0; tick(4);
            rd(0, 10, v); chk("R4 inverted fall latched", v, 32'(1) << j);
            wr(0, 11, 32'(1) << j);
        end
        wr(0, 7, 0);
        tick(4);
        wr(0, 11, 32'hFFFF_FFFF);

        // R10: exact latency of an edge
        @(negedge clk);
        reg_addr = {3'd0, 4'd10};
        pins[8] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R10 not yet after two edges", reg_rdata, 0);
        @(posedge clk); #1;
        chk("R10 latched at third edge", reg_rdata, 32'h1);
        pins[8] = 1'b0;
        tick(4);
        wr(0, 11, 32'hFFFF_FFFF);

        // R8: clear in the same cycle as a new edge wins
        @(negedge clk);
        pins[10] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = {3'd0, 4'd11}; reg_wdata = 32'h4;
        @(negedge clk);
        reg_we = 1'b0;
        rd(0, 10, v); chk("R8 clear beats edge", v, 0);
        chk("R8 irq stays low", 32'(irq), 0);
        pins[10] = 1'b0;
        tick(4);

        // R5: level bits follow pin XOR inversion, clear has no effect
        wr(0, 6, 32'hFF);
        tick(1);
        rd(0, 10, v); chk("R5 level idle", v, 0);
        pins[13] = 1'b1; tick(4);
        rd(0, 10, v); chk("R5 level high", v, 32'h20);
        wr(0, 11, 32'h20);
        rd(0, 10, v); chk("R5 clear ignored", v, 32'h20);
        pins[13] = 1'b0; tick(4);
        rd(0, 10, v); chk("R5 level released", v, 0);
        wr(0, 7, 32'h02);
        tick(1);
        rd(0, 10, v); chk("R5 inverted low active", v, 32'h02);
        pins[9] = 1'b1; tick(4);
        rd(0, 10, v); chk("R5 inverted high idle", v, 0);
        pins[9] = 1'b0;
        wr(0, 7, 0);
        wr(0, 5, 32'hFF);
        tick(4);
        wr(0, 11, 32'hFFFF_FFFF);

        // R6: latch works while masked
        wr(0, 1, 0);
        pins[15] = 1'b1; tick(4);
        rd(0, 10, v); chk("R6 latched while masked", v, 32'h80);
        chk("R6 irq masked", 32'(irq), 0);
        wr(0, 2, 32'h80);
        #1 chk("R6 irq after unmask", 32'(irq), 1);
        wr(0, 11, 32'h80);
        pins[15] = 1'b0; tick(4);

        // R7 / R9: two channels share half-port 1
        wr(3, 0, 32'h0081_0000);
        wr(3, 4, 32'hFFFF_FFFF);
        wr(3, 1, 32'hFFFF_FFFF);
        tick(4);
        wr(3, 11, 32'hFFFF_FFFF);
        wr(0, 1, 32'hFFFF_FFFF);
        #1 chk("R7 idle", 32'(irq), 0);
        pins[8] = 1'b1; tick(4);
        chk("R7 both channels", 32'(irq), 32'h09);
        rd(3, 10, v); chk("R9 shared latch slot2", v, 32'h0001_0000);
        wr(0, 11, 32'h1);
        #1 chk("R9 other channel unaffected irq", 32'(irq), 32'h08);
        rd(3, 10, v); chk("R9 other channel latch", v, 32'h0001_0000);
        wr(3, 3, 32'h0001_0000);
        #1 chk("R7 masked out", 32'(irq), 0);
        rd(3, 10, v); chk("R6 masked latch kept", v, 32'h0001_0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule